// File: doc/BRIEF.md
# Watch Mode Wake-Up Sequencer

This block sequences the power modes of a small controller around a clock-stopped watch state. From an active mode, a sleep request parks the block in watch mode. A qualified wake event then moves it to a new operating mode, and the event can be a watchdog overflow, the non-maskable interrupt, an enabled external IRQ line, or an enabled and unmasked peripheral request. A low-speed select bit picks the subactive target. Otherwise a medium-speed select bit picks medium speed, and if neither is set the target is high speed.

Only the high-speed path waits for the oscillator. A down-counter holds the block in a settling state for 2^(SETTLE_BASE_LOG2 + sel) cycles, where sel is a 3-bit field. By default these counts run from 2^13 to 2^20. The exception-start pulse is issued only once the target mode is reached.

Reset overrides everything. The active-low standby pin comes next and sends the block to hardware standby. While the block is in watch or settling, the bus-output enable follows the output-port-enable bit.

Top module: `wake_seq_top`

## Requirements
- R1: While rst_n is low, mode is 0 (reset), and clk_stable, exc_start and bus_oe are 0. After rst_n rises, mode stays 0 for two rising edges and becomes 1 (high speed) on the third, with clk_stable at 1.
- R2: In mode 1, 2 or 3 with stby_n high, sleep_req at 1 moves mode to 4 (watch) on the next rising edge, and clk_stable is 0 in watch.
- R3: In watch, a wake event is any of: wdt_ovf; nmi; irq[i] with irq_en[i] at 1; per_req[j] with per_en[j] at 1 and cpu_mask at 0. An IRQ with its enable at 0, a disabled peripheral request, or a peripheral request under cpu_mask at 1 leaves mode at 4.
- R4: A wake with low_speed_sel at 1 moves mode to 3 (subactive) on the next edge, with exc_start at 1 in that same cycle.
- R5: A wake with low_speed_sel at 0 and medium_sel at 1 moves mode to 2 (medium speed) on the next edge, with exc_start at 1 in that cycle.
- R6: A wake with both select bits at 0 moves mode to 6 (settling) for exactly 2^(SETTLE_BASE_LOG2 + sts_sel) cycles with clk_stable at 0. Mode then becomes 1, with exc_start at 1 in the first high-speed cycle.
- R7: exc_start is never high for two cycles in a row, and is never high in settling.
- R8: stby_n low moves mode to 5 (hardware standby) on the next edge from any mode, ahead of any wake. Only reset leaves mode 5.
- R9: bus_oe is 1 in modes 1, 2 and 3. It equals ope in modes 4 and 6, and it is 0 in modes 0 and 5.
- R10: sts_sel is sampled at the wake edge, and changing it during settling does not alter the settling length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_n | input | 1 | Active-low hardware standby request |
| sleep_req | input | 1 | Enter watch mode from an active mode |
| wdt_ovf | input | 1 | Watchdog overflow interrupt |
| nmi | input | 1 | Non-maskable interrupt |
| irq | input | NUM_IRQ | External interrupt lines |
| irq_en | input | NUM_IRQ | Per-line IRQ enables |
| per_req | input | NUM_PER | Peripheral interrupt requests |
| per_en | input | NUM_PER | Peripheral interrupt enables |
| cpu_mask | input | 1 | CPU mask over peripheral requests |
| low_speed_sel | input | 1 | Wake target is subactive when 1 |
| medium_sel | input | 1 | Wake target is medium speed when 1 and low_speed_sel is 0 |
| sts_sel | input | 3 | Settling time select |
| ope | input | 1 | Keep bus outputs driven in watch and settling |
| mode | output | 3 | Current mode code |
| clk_stable | output | 1 | Clock usable by active logic |
| exc_start | output | 1 | One-cycle start of exception processing |
| bus_oe | output | 1 | Bus and bus-control output enable |

## Verification
The assertions check on every cycle the gating of wake sources in watch, the single-cycle exception pulse, the low clock-stable flag in settling, the standby override and the bus-enable decode. Only the bench's scenarios can show the exact settling length for each of the eight select codes. The same holds for the deaf select field during settling, the reset release timing, and the fact that each IRQ line and each peripheral line wakes only under its own enable.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [2:0] {
    M_RESET  = 3'd0,
    M_HIGH   = 3'd1,
    M_MEDIUM = 3'd2,
    M_SUBACT = 3'd3,
    M_WATCH  = 3'd4,
    M_HWSTBY = 3'd5,
    M_SETTLE = 3'd6
  } mode_e;

  localparam int STS_W = 3;
endpackage

// File: rtl/wake_detect.sv
module wake_detect #(
  parameter int NUM_IRQ = 6,
  parameter int NUM_PER = 4
) (
  input  logic               wdt_ovf,
  input  logic               nmi,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_PER-1:0] per_req,
  input  logic [NUM_PER-1:0] per_en,
  input  logic               cpu_mask,
  output logic               wake
);
  logic [NUM_IRQ-1:0] irq_q;
  logic [NUM_PER-1:0] per_q;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_IRQ; gi++) begin : g_irq
      assign irq_q[gi] = irq[gi] & irq_en[gi];
    end
    for (gi = 0; gi < NUM_PER; gi++) begin : g_per
      assign per_q[gi] = per_req[gi] & per_en[gi] & ~cpu_mask;
    end
  endgenerate

  assign wake = wdt_ovf | nmi | (|irq_q) | (|per_q);
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_BASE_LOG2 = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     run,
  input  logic [wake_pkg::STS_W-1:0] sel,
  output logic                     done
);
  localparam int CW = SETTLE_BASE_LOG2 + 8;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] load_val;
  logic          cnt_en;

  assign load_val = (CW'(1) << (SETTLE_BASE_LOG2 + int'(sel))) - CW'(1);
  assign cnt_en   = load | (run & (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (run) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = run & (cnt_q == '0);
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stby_n,
  input  logic           sleep_req,
  input  logic           wake,
  input  logic           low_speed_sel,
  input  logic           medium_sel,
  input  logic           settle_done,
  output wake_pkg::mode_e state,
  output logic           settle_load,
  output logic           exc_start
);
  import wake_pkg::*;

  mode_e state_d;
  logic  exc_d;

  always_comb begin
    state_d     = state;
    exc_d       = 1'b0;
    settle_load = 1'b0;
    if (!stby_n) begin
      state_d = M_HWSTBY;
    end else begin
      unique case (state)
        M_RESET: state_d = M_HIGH;
        M_HIGH, M_MEDIUM, M_SUBACT: begin
          if (sleep_req) state_d = M_WATCH;
        end
        M_WATCH: begin
          if (wake) begin
            if (low_speed_sel) begin
              state_d = M_SUBACT;
              exc_d   = 1'b1;
            end else if (medium_sel) begin
              state_d = M_MEDIUM;
              exc_d   = 1'b1;
            end else begin
              state_d     = M_SETTLE;
              settle_load = 1'b1;
            end
          end
        end
        M_SETTLE: begin
          if (settle_done) begin
            state_d = M_HIGH;
            exc_d   = 1'b1;
          end
        end
        M_HWSTBY: state_d = M_HWSTBY;
        default:  state_d = M_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= M_RESET;
      exc_start <= 1'b0;
    end else begin
      state     <= state_d;
      exc_start <= exc_d;
    end
  end
endmodule

// File: rtl/wake_seq_top.sv
module wake_seq_top #(
  parameter int NUM_IRQ          = 6,
  parameter int NUM_PER          = 4,
  parameter int SETTLE_BASE_LOG2 = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stby_n,
  input  logic               sleep_req,
  input  logic               wdt_ovf,
  input  logic               nmi,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_PER-1:0] per_req,
  input  logic [NUM_PER-1:0] per_en,
  input  logic               cpu_mask,
  input  logic               low_speed_sel,
  input  logic               medium_sel,
  input  logic [2:0]         sts_sel,
  input  logic               ope,
  output logic [2:0]         mode,
  output logic               clk_stable,
  output logic               exc_start,
  output logic               bus_oe
);
  import wake_pkg::*;

  logic  rst_s1, rst_i;
  logic  wake, settle_load, settle_done;
  mode_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  wake_detect #(.NUM_IRQ(NUM_IRQ), .NUM_PER(NUM_PER)) u_det (
    .wdt_ovf(wdt_ovf), .nmi(nmi), .irq(irq), .irq_en(irq_en),
    .per_req(per_req), .per_en(per_en), .cpu_mask(cpu_mask), .wake(wake)
  );

  settle_timer #(.SETTLE_BASE_LOG2(SETTLE_BASE_LOG2)) u_tmr (
    .clk(clk), .rst_n(rst_i), .load(settle_load),
    .run(state == M_SETTLE), .sel(sts_sel), .done(settle_done)
  );

  mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_i), .stby_n(stby_n), .sleep_req(sleep_req),
    .wake(wake), .low_speed_sel(low_speed_sel), .medium_sel(medium_sel),
    .settle_done(settle_done), .state(state), .settle_load(settle_load),
    .exc_start(exc_start)
  );

  always_comb begin
    mode = state;
    unique case (state)
      M_HIGH, M_MEDIUM, M_SUBACT: begin clk_stable = 1'b1; bus_oe = 1'b1; end
      M_WATCH, M_SETTLE:          begin clk_stable = 1'b0; bus_oe = ope;  end
      default:                    begin clk_stable = 1'b0; bus_oe = 1'b0; end
    endcase
  end
endmodule

// File: rtl/wake_seq_chk.sv
module wake_seq_chk #(
  parameter int NUM_IRQ = 6,
  parameter int NUM_PER = 4
) (
  input logic               clk,
  input logic               rst_ok,
  input logic               stby_n,
  input logic               wdt_ovf,
  input logic               nmi,
  input logic [NUM_IRQ-1:0] irq,
  input logic [NUM_IRQ-1:0] irq_en,
  input logic [NUM_PER-1:0] per_req,
  input logic [NUM_PER-1:0] per_en,
  input logic               cpu_mask,
  input logic               low_speed_sel,
  input logic               ope,
  input logic [2:0]         mode,
  input logic               clk_stable,
  input logic               exc_start,
  input logic               bus_oe
);
  logic qual;
  assign qual = wdt_ovf | nmi | (|(irq & irq_en)) | ((|(per_req & per_en)) & ~cpu_mask);

  // R3: no qualified source keeps the block in watch
  a_r3_gated_stay: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode == 3'd4 && stby_n && !qual) |=> mode == 3'd4);

  // R4: low-speed wake lands in subactive with the pulse
  a_r4_subact: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode == 3'd4 && stby_n && qual && low_speed_sel) |=> (mode == 3'd3 && exc_start));

  // R6: settling leads only to settling or high speed
  a_r6_settle_exit: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode == 3'd6 && stby_n) |=> (mode == 3'd6 || mode == 3'd1));

  // R6, R7: clock not stable and no pulse while settling
  a_r7_settle_quiet: assert property (@(posedge clk) disable iff (!rst_ok)
    mode == 3'd6 |-> (!clk_stable && !exc_start));

  // R7: pulse lasts one cycle
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_ok)
    exc_start |=> !exc_start);

  // R8: standby pin wins over any wake
  a_r8_standby: assert property (@(posedge clk) disable iff (!rst_ok)
    !stby_n |=> mode == 3'd5);

  // R9: bus enable follows ope in watch and settling
  a_r9_bus_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode == 3'd4 || mode == 3'd6) |-> bus_oe == ope);
endmodule

bind wake_seq_top wake_seq_chk #(.NUM_IRQ(NUM_IRQ), .NUM_PER(NUM_PER)) u_chk (
  .clk(clk), .rst_ok(rst_i), .stby_n(stby_n), .wdt_ovf(wdt_ovf), .nmi(nmi),
  .irq(irq), .irq_en(irq_en), .per_req(per_req), .per_en(per_en),
  .cpu_mask(cpu_mask), .low_speed_sel(low_speed_sel), .ope(ope), .mode(mode),
  .clk_stable(clk_stable), .exc_start(exc_start), .bus_oe(bus_oe)
);

// File: tb/sim_wake_seq_top.sv
`timescale 1ns/1ps
module sim_wake_seq_top;
  localparam int NI = 6;
  localparam int NP = 4;
  localparam int BASE = 2;

  logic clk = 1'b0;
  logic rst_n, stby_n, sleep_req, wdt_ovf, nmi, cpu_mask;
  logic low_speed_sel, medium_sel, ope;
  logic [NI-1:0] irq, irq_en;
  logic [NP-1:0] per_req, per_en;
  logic [2:0] sts_sel;
  logic [2:0] mode;
  logic clk_stable, exc_start, bus_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wake_seq_top #(.NUM_IRQ(NI), .NUM_PER(NP), .SETTLE_BASE_LOG2(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .sleep_req(sleep_req),
    .wdt_ovf(wdt_ovf), .nmi(nmi), .irq(irq), .irq_en(irq_en),
    .per_req(per_req), .per_en(per_en), .cpu_mask(cpu_mask),
    .low_speed_sel(low_speed_sel), .medium_sel(medium_sel), .sts_sel(sts_sel),
    .ope(ope), .mode(mode), .clk_stable(clk_stable), .exc_start(exc_start),
    .bus_oe(bus_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic quiet();
    wdt_ovf = 0; nmi = 0; irq = '0; per_req = '0; sleep_req = 0;
  endtask

  task automatic do_reset();
    quiet(); stby_n = 1; rst_n = 0;
    tick(); tick();
    rst_n = 1;
    tick(); tick(); tick();
  endtask

  task automatic to_watch();
    quiet(); sleep_req = 1; tick(); sleep_req = 0;
  endtask

  initial begin
    quiet(); stby_n = 1; irq_en = '0; per_en = '0; cpu_mask = 0;
    low_speed_sel = 0; medium_sel = 0; sts_sel = 0; ope = 0;
    rst_n = 0;
    @(negedge clk);
    chk("R1 reset mode", mode, 0);
    chk("R1 reset clk_stable", clk_stable, 0);
    chk("R1 reset exc", exc_start, 0);
    chk("R1 reset bus_oe", bus_oe, 0);
    tick();
    rst_n = 1;
    tick(); tick();
    chk("R1 held after 2 edges", mode, 0);
    tick();
    chk("R1 high after 3 edges", mode, 1);
    chk("R1 clk_stable", clk_stable, 1);
    chk("R9 bus_oe high", bus_oe, 1);

    // R2 and R9 in watch, both ope values
    for (int o = 0; o < 2; o++) begin
      ope = o[0];
      to_watch();
      chk("R2 watch", mode, 4);
      chk("R2 clk_stable low", clk_stable, 0);
      chk("R9 bus_oe=ope watch", bus_oe, o);
      low_speed_sel = 1; nmi = 1; tick(); quiet();
      chk("R4 subact", mode, 3);
      chk("R4 exc", exc_start, 1);
      tick();
      chk("R7 exc single", exc_start, 0);
    end

    // R3 IRQ sweep
    low_speed_sel = 1;
    for (int i = 0; i < NI; i++) begin
      to_watch();
      irq_en = '1; irq_en[i] = 1'b0; irq = '0; irq[i] = 1'b1;
      tick(); tick();
      chk($sformatf("R3 irq%0d disabled", i), mode, 4);
      irq_en[i] = 1'b1; tick(); quiet();
      chk($sformatf("R3 irq%0d enabled", i), mode, 3);
    end
    irq_en = '0;
    // R3 peripheral sweep
    for (int j = 0; j < NP; j++) begin
      to_watch();
      per_en = '1; per_en[j] = 1'b0; per_req = '0; per_req[j] = 1'b1;
      tick();
      chk($sformatf("R3 per%0d disabled", j), mode, 4);
      per_en[j] = 1'b1; cpu_mask = 1; tick();
      chk($sformatf("R3 per%0d masked", j), mode, 4);
      cpu_mask = 0; tick(); quiet();
      chk($sformatf("R3 per%0d enabled", j), mode, 3);
    end
    per_en = '0;
    to_watch(); wdt_ovf = 1; tick(); quiet();
    chk("R3 wdt wake", mode, 3);

    // R5 medium
    low_speed_sel = 0; medium_sel = 1;
    to_watch(); nmi = 1; tick(); quiet();
    chk("R5 medium", mode, 2);
    chk("R5 exc", exc_start, 1);
    tick();
    chk("R7 exc single medium", exc_start, 0);

    // R6 settling sweep over all select codes
    medium_sel = 0; ope = 1;
    for (int s = 0; s < 8; s++) begin
      int n;
      to_watch();
      sts_sel = s[2:0]; nmi = 1; tick(); quiet();
      chk("R9 bus_oe=ope settle", bus_oe, 1);
      n = 0;
      while (mode == 3'd6 && n < 5000) begin
        if (clk_stable) chk("R6 clk_stable in settle", 1, 0);
        n++; tick();
      end
      chk($sformatf("R6 settle len sel%0d", s), n, 1 << (BASE + s));
      chk("R6 high after settle", mode, 1);
      chk("R6 exc after settle", exc_start, 1);
      tick();
      chk("R7 exc single high", exc_start, 0);
    end

    // R10 select changed during settling
    begin
      int n;
      to_watch();
      sts_sel = 3'd1; nmi = 1; tick(); quiet();
      sts_sel = 3'd7;
      n = 0;
      while (mode == 3'd6 && n < 5000) begin n++; tick(); end
      chk("R10 sampled select", n, 1 << (BASE + 1));
      sts_sel = 0;
    end

    // R8 standby wins over wake, held until reset
    to_watch(); nmi = 1; low_speed_sel = 1; stby_n = 0; tick(); quiet();
    chk("R8 standby over wake", mode, 5);
    chk("R9 bus_oe standby", bus_oe, 0);
    stby_n = 1; nmi = 1; tick(); tick(); quiet();
    chk("R8 standby held", mode, 5);
    do_reset();
    chk("R1 reset leaves standby", mode, 1);
    stby_n = 0; tick(); stby_n = 1;
    chk("R8 standby from high", mode, 5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule